// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

The controller gathers request strobes from sixteen interrupt sources into a pending register. Every asserted source sets its pending bit, whether or not that source is masked and whether or not interrupts are globally enabled. A request counts as eligible only when three things hold at once: its pending bit is set, its mask bit is set, and the global enable is on. Among the eligible requests, the one with the highest index is offered to the processor together with its four-bit vector number.

Software reaches the block through a small byte-wide register file. Two separate registers hold the masks: one for sources 0 to 7 and one for sources 8 to 15. Two more registers expose the pending bits, and a status byte carries the global enable. After servicing a request, the processor returns an acknowledge pulse naming the vector, and that pulse clears only the named pending bit. Pending requests that built up while the sources were blocked are then served one by one in priority order once they become enabled.

Top module: `masked_prio_intc`

## Requirements
- R1: After reset, all pending bits, both mask registers and the global enable are 0, and irqValid is 0.
- R2: The low mask (sources 7..0, bit n = source n) is read and written at address 0x08. The high mask (sources 15..8, bit n = source 8+n) is read and written at address 0x13. Writes take effect on the clock edge, and reads are combinational.
- R3: The global enable is bit 1 of the status byte at address 0x01. The other status bits read as 0.
- R4: A high srcReq[i] in a cycle sets pending bit i at the following edge, whatever the mask and global enable hold.
- R5: irqValid is 1 only when the global enable is 1 and at least one source has both its pending bit and its mask bit set.
- R6: When irqValid is 1, irqVector is the highest index among the eligible sources.
- R7: An ackValid cycle clears exactly pending bit ackVector at the next edge and leaves every other pending bit as it was.
- R8: If srcReq[i] is high in the same cycle as an acknowledge of vector i, pending bit i stays set.
- R9: Pending bits 7..0 are readable and writable at 0x09, and bits 15..8 at 0x12, so writing 0 clears a stale request. A source request in the same cycle as the write still sets its bit.
- R10: Addresses other than 0x01, 0x08, 0x09, 0x12 and 0x13 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 16 | Per-source request strobes |
| regWe | input | 1 | Register write enable |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| ackValid | input | 1 | Acknowledge pulse from the processor |
| ackVector | input | 4 | Index of the acknowledged source |
| irqValid | output | 1 | An eligible request is present |
| irqVector | output | 4 | Index of the winning source |

## Verification
Directed patterns come first. Requests arrive with the global enable off, which separates pending capture from servicing. A lone low source and a lone high source then compete while the top source's mask is cleared and then set, which tells masking apart from priority. Acknowledges are applied with and without a same-cycle request on the same source, which exposes the ordering of clear and set. Pending-register writes are made with and without a colliding request, and unmapped writes are made to catch decode errors. A long random phase then mixes sparse requests, register writes and acknowledges of the presented vector, and a behavioural model is compared on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int SRC_N = 16;
  localparam int VEC_W = $clog2(SRC_N);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK_LO, SEL_MASK_HI, SEL_PEND_LO, SEL_PEND_HI, SEL_STAT
  } rdSel_t;

  typedef struct packed {
    logic             wrMaskLo;
    logic             wrMaskHi;
    logic             wrPendLo;
    logic             wrPendHi;
    logic             wrStat;
    logic [SRC_N-1:0] ackClr;
  } intcStrobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_STAT    = 8'h01,
  parameter logic [ADDR_W-1:0] A_MASK_LO = 8'h08,
  parameter logic [ADDR_W-1:0] A_PEND_LO = 8'h09,
  parameter logic [ADDR_W-1:0] A_PEND_HI = 8'h12,
  parameter logic [ADDR_W-1:0] A_MASK_HI = 8'h13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic             ackValid,
  input  logic [VEC_W-1:0] ackVector,
  input  logic [SRC_N-1:0] eligible,
  output intcStrobes_t     strb,
  output rdSel_t           rdSel,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);
  // address decode
  always_comb begin
    rdSel = SEL_NONE;
    unique case (regAddr)
      A_STAT:    rdSel = SEL_STAT;
      A_MASK_LO: rdSel = SEL_MASK_LO;
      A_MASK_HI: rdSel = SEL_MASK_HI;
      A_PEND_LO: rdSel = SEL_PEND_LO;
      A_PEND_HI: rdSel = SEL_PEND_HI;
      default:   rdSel = SEL_NONE;
    endcase
  end

  assign strb.wrStat   = regWe && (rdSel == SEL_STAT);
  assign strb.wrMaskLo = regWe && (rdSel == SEL_MASK_LO);
  assign strb.wrMaskHi = regWe && (rdSel == SEL_MASK_HI);
  assign strb.wrPendLo = regWe && (rdSel == SEL_PEND_LO);
  assign strb.wrPendHi = regWe && (rdSel == SEL_PEND_HI);

  // acknowledge decode, one lane per source
  for (genvar g = 0; g < SRC_N; g++) begin : g_ack
    assign strb.ackClr[g] = ackValid && (ackVector == VEC_W'(g));
  end

  // priority encoder: highest index wins
  always_comb begin
    irqVector = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (eligible[i]) irqVector = VEC_W'(i);
    end
  end
  assign irqValid = |eligible;

  // R6: presented vector is eligible and nothing above it is
  a_r6_highest_wins: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((eligible >> irqVector) == SRC_N'(1)));

  // R10: at most one register write strobe per cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrStat, strb.wrMaskLo, strb.wrMaskHi, strb.wrPendLo, strb.wrPendHi}));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int GIE_BIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  intcStrobes_t     strb,
  input  rdSel_t           rdSel,
  input  logic [SRC_N/2-1:0] wdata,
  input  logic [SRC_N-1:0] srcReq,
  output logic [SRC_N-1:0] eligible,
  output logic [SRC_N/2-1:0] rdata
);
  localparam int BYTE_W = SRC_N / 2;

  logic [BYTE_W-1:0] maskLo, maskHi;
  logic [SRC_N-1:0]  pend, pendNext;
  logic              gie;

  // software write, then acknowledge clear, then new requests
  always_comb begin
    pendNext = pend;
    if (strb.wrPendLo) pendNext[BYTE_W-1:0]     = wdata;
    if (strb.wrPendHi) pendNext[SRC_N-1:BYTE_W] = wdata;
    pendNext = (pendNext & ~strb.ackClr) | srcReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskLo <= '0;
      maskHi <= '0;
      pend   <= '0;
      gie    <= 1'b0;
    end else begin
      if (strb.wrMaskLo) maskLo <= wdata;
      if (strb.wrMaskHi) maskHi <= wdata;
      if (strb.wrStat)   gie    <= wdata[GIE_BIT];
      pend <= pendNext;
    end
  end

  assign eligible = gie ? (pend & {maskHi, maskLo}) : '0;

  always_comb begin
    rdata = '0;
    unique case (rdSel)
      SEL_MASK_LO: rdata = maskLo;
      SEL_MASK_HI: rdata = maskHi;
      SEL_PEND_LO: rdata = pend[BYTE_W-1:0];
      SEL_PEND_HI: rdata = pend[SRC_N-1:BYTE_W];
      SEL_STAT:    rdata[GIE_BIT] = gie;
      default:     rdata = '0;
    endcase
  end

  // R4: any request is captured at the next edge
  a_r4_req_captured: assert property (@(posedge clk) disable iff (!rstN)
    (srcReq != '0) |=> ((pend & $past(srcReq)) == $past(srcReq)));

  // R7: acknowledged bit without a colliding request or write is cleared
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (((strb.ackClr & ~srcReq) != '0) && !strb.wrPendLo && !strb.wrPendHi)
      |=> ((pend & $past(strb.ackClr & ~srcReq)) == '0));

  // R9: no pending bit appears without a request or a pending write
  a_r9_no_spurious_pend: assert property (@(posedge clk) disable iff (!rstN)
    ((srcReq == '0) && !strb.wrPendLo && !strb.wrPendHi) |=> ((pend & ~$past(pend)) == '0));

  // R2: masks hold when not written
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrMaskLo && !strb.wrMaskHi) |=> ($stable(maskLo) && $stable(maskHi)));

  // R5: no eligible source while globally disabled
  a_r5_gie_gate: assert property (@(posedge clk) disable iff (!rstN)
    !gie |-> (eligible == '0));
endmodule

// File: rtl/masked_prio_intc.sv
module masked_prio_intc
  import intc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int GIE_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       srcReq,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              ackValid,
  input  logic [3:0]        ackVector,
  output logic              irqValid,
  output logic [3:0]        irqVector
);
  intcStrobes_t     strb;
  rdSel_t           rdSel;
  logic [SRC_N-1:0] eligible;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .ackValid(ackValid), .ackVector(ackVector), .eligible(eligible),
    .strb(strb), .rdSel(rdSel), .irqValid(irqValid), .irqVector(irqVector)
  );

  intc_datapath #(.GIE_BIT(GIE_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .wdata(regWdata),
    .srcReq(srcReq), .eligible(eligible), .rdata(regRdata)
  );

  // R1: nothing is offered in the cycle right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !irqValid);
endmodule

// File: tb/sim_masked_prio_intc.sv
`timescale 1ns/1ps
module sim_masked_prio_intc;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic [15:0] srcReq = '0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0, regWdata = '0, regRdata;
  logic        ackValid = 1'b0;
  logic [3:0]  ackVector = '0;
  logic        irqValid;
  logic [3:0]  irqVector;

  masked_prio_intc u0 (.*);

  int checks = 0, fails = 0;
  logic [15:0] mPend = '0;
  logic [7:0]  mLo = '0, mHi = '0;
  logic        mGie = 1'b0;
  logic [7:0]  lastRd;
  logic        lastValid;
  logic [3:0]  lastVec;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mRead(logic [7:0] a);
    case (a)
      8'h01: return {6'b0, mGie, 1'b0};
      8'h08: return mLo;
      8'h13: return mHi;
      8'h09: return mPend[7:0];
      8'h12: return mPend[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] mElig();
    return mGie ? (mPend & {mHi, mLo}) : 16'h0;
  endfunction

  function automatic int mVec();
    int v = 0;
    logic [15:0] e = mElig();
    for (int i = 0; i < 16; i++) if (e[i]) v = i;
    return v;
  endfunction

  // drive one cycle, compare against the model, advance the model at the edge
  task automatic tick(logic [15:0] req, logic we, logic [7:0] a, logic [7:0] d,
                      logic av, logic [3:0] vec);
    srcReq = req; regWe = we; regAddr = a; regWdata = d; ackValid = av; ackVector = vec;
    #1;
    lastRd = regRdata; lastValid = irqValid; lastVec = irqVector;
    chk("R5 irqValid", int'(irqValid), int'(mElig() != 0));
    if (mElig() != 0) chk("R6 irqVector", int'(irqVector), mVec());
    chk("R2 regRdata", int'(regRdata), int'(mRead(a)));
    @(posedge clk);
    if (we) begin
      case (a)
        8'h01: mGie = d[1];
        8'h08: mLo = d;
        8'h13: mHi = d;
        8'h09: mPend[7:0] = d;
        8'h12: mPend[15:8] = d;
        default: ;
      endcase
    end
    if (av) mPend[vec] = 1'b0;
    mPend = mPend | req;
    @(negedge clk);
  endtask

  task automatic peek(logic [7:0] a);
    tick('0, 1'b0, a, '0, 1'b0, '0);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    tick('0, 1'b1, a, d, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    peek(8'h09); chk("R1 pend lo", lastRd, 0); chk("R1 irqValid", lastValid, 0);
    peek(8'h12); chk("R1 pend hi", lastRd, 0);
    peek(8'h08); chk("R1 mask lo", lastRd, 0);
    peek(8'h01); chk("R1 status", lastRd, 0);
    // R2 masks
    wr(8'h08, 8'hA5); wr(8'h13, 8'h3C);
    peek(8'h08); chk("R2 mask lo", lastRd, 8'hA5);
    peek(8'h13); chk("R2 mask hi", lastRd, 8'h3C);
    // R10 unmapped
    wr(8'h20, 8'hFF); peek(8'h20); chk("R10 unmapped read", lastRd, 0);
    peek(8'h08); chk("R10 mask untouched", lastRd, 8'hA5);
    // R4 capture while globally disabled
    tick(16'h8001, 1'b0, 8'h00, '0, 1'b0, '0);
    peek(8'h09); chk("R4 pend lo", lastRd, 8'h01); chk("R5 gated off", lastValid, 0);
    peek(8'h12); chk("R4 pend hi", lastRd, 8'h80);
    // R3 global enable
    wr(8'h01, 8'hFF); peek(8'h01); chk("R3 status", lastRd, 8'h02);
    chk("R6 only low enabled", lastVec, 0); chk("R5 valid", lastValid, 1);
    wr(8'h13, 8'hBC); peek(8'h00); chk("R6 highest", lastVec, 15);
    // R7 ack clears
    tick('0, 1'b0, 8'h00, '0, 1'b1, 4'd15);
    peek(8'h12); chk("R7 cleared", lastRd, 0); chk("R7 next vector", lastVec, 0);
    peek(8'h09); chk("R7 others kept", lastRd, 8'h01);
    // R8 ack with same-cycle request
    tick(16'h0001, 1'b0, 8'h00, '0, 1'b1, 4'd0);
    peek(8'h09); chk("R8 bit kept", lastRd, 8'h01);
    // R9 software clear and collision
    wr(8'h09, 8'h00); peek(8'h09); chk("R9 cleared", lastRd, 0); chk("R9 no valid", lastValid, 0);
    tick(16'h0200, 1'b1, 8'h12, 8'h00, 1'b0, '0);
    peek(8'h12); chk("R9 req wins", lastRd, 8'h02);
    wr(8'h13, 8'hFF); peek(8'h00); chk("R6 vector 9", lastVec, 9);
    wr(8'h01, 8'h00); peek(8'h00); chk("R5 disabled", lastValid, 0);
    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [15:0] rq;
      logic [7:0]  a;
      logic        w, av;
      int          sel;
      rq = 16'(($urandom % 4 == 0) ? (16'h1 << ($urandom % 16)) : 0);
      sel = $urandom % 7;
      a = (sel == 0) ? 8'h01 : (sel == 1) ? 8'h08 : (sel == 2) ? 8'h13 :
          (sel == 3) ? 8'h09 : (sel == 4) ? 8'h12 : 8'(($urandom % 64));
      w = ($urandom % 5 == 0);
      av = irqValid && ($urandom % 2 == 0);
      tick(rq, w, a, 8'($urandom), av, irqVector);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule